// File: doc/BRIEF.md
# PHY Latching Status Register Bank

This block is a read-only status register bank for a 10 Mbps Ethernet PHY. It takes conditions from the PHY datapath as live inputs: link up, jabber detected, transmit active, receive active, collision, full-duplex configuration and reversed receive polarity. It presents them to a host as two 16-bit status words. The host reads them through a plain register port made of an address, a read strobe and registered read data.

The first word holds sticky information. Its link bit latches low, so a host that polls the word learns whether the link dropped at any time since its previous poll. Its jabber bit latches high, so a short jabber burst is not missed. Reading the first word re-arms both latches. The second word shows the same kinds of condition live, with no latching. A host uses it to see the present state of the link and of the datapath.

All live inputs are taken to be synchronous to the register clock already. Read data appears one cycle after the strobe and holds until the next strobe.

Top module: `phy_stat_regs`

## Requirements
- R1: The link bit of word 1 (bit 2) reads 1 only if the link input has been 1 in every cycle since the previous read of word 1. A link-down in any cycle makes it read 0 at the next read of word 1.
- R2: The jabber bit of word 1 (bit 1) becomes 1 after any cycle in which the jabber input is 1. It stays 1 until word 1 is read.
- R3: After reset, rdata_o is 0. Both latched bits are 0, so the first read of word 1 returns 0x1800.
- R4: Word 1 always has bit 12 (full-duplex capable) and bit 11 (half-duplex capable) set to 1. All bits other than 12, 11, 2 and 1 read 0.
- R5: Word 2 is live and unlatched. Bit 13 is transmit active, bit 12 is receive active, bit 11 is collision, bit 10 is the live link input, bit 9 is duplex (1 means full) and bit 5 is reversed polarity. All other bits read 0.
- R6: A read of word 1 returns the latched bits as they stood before that read. In the same cycle the link latch reloads from the link input and the jabber latch reloads from the jabber input.
- R7: A link-down or a jabber event in the cycle of a word 1 read is reported by the following read of word 1.
- R8: Reading word 2 or an unmapped address leaves both latches unchanged. An unmapped address returns 0.
- R9: Read data is registered. The value for a strobe sampled at a clock edge appears after that edge, and rdata_o holds its value while no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_i | input | 1 | Link is up (live) |
| jabber_i | input | 1 | Jabber condition detected this cycle |
| tx_act_i | input | 1 | PHY is transmitting |
| rx_act_i | input | 1 | PHY is receiving |
| coll_i | input | 1 | Collision in progress |
| full_dpx_i | input | 1 | PHY is configured for full duplex |
| pol_rev_i | input | 1 | Receive polarity is reversed |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (5) | Register address: 0x01 is word 1, 0x11 is word 2 |
| rdata_o | output | 16 | Registered read data |

## Verification
The bench drops the link for a single cycle between two reads. A design that only samples the link at read time would then wrongly report the link as up. It places a link-down and a jabber pulse in the very cycle of a word 1 read. A design that gives the re-arm priority over the event would lose that event at the next read. It also pulses both events before reading word 2 and an unmapped address. A design that decodes reads loosely would clear the latches there, and a later word 1 read would show it. Every bit of word 2 is driven alone, which exposes swapped or shifted field positions.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;

  localparam int WORD_W = 16;

  localparam int B1_FDPX_CAP = 12;
  localparam int B1_HDPX_CAP = 11;
  localparam int B1_LINK_LAT = 2;
  localparam int B1_JAB_LAT  = 1;

  localparam int B2_TX   = 13;
  localparam int B2_RX   = 12;
  localparam int B2_COL  = 11;
  localparam int B2_LINK = 10;
  localparam int B2_DPX  = 9;
  localparam int B2_POL  = 5;

  typedef struct packed {
    logic tx;
    logic rx;
    logic col;
    logic link;
    logic dpx;
    logic pol;
  } live_t;

  function automatic logic [WORD_W-1:0] pack_word1(input logic link_lat, input logic jab_lat);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B1_FDPX_CAP] = 1'b1;
    w[B1_HDPX_CAP] = 1'b1;
    w[B1_LINK_LAT] = link_lat;
    w[B1_JAB_LAT]  = jab_lat;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word2(input live_t lv);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B2_TX]   = lv.tx;
    w[B2_RX]   = lv.rx;
    w[B2_COL]  = lv.col;
    w[B2_LINK] = lv.link;
    w[B2_DPX]  = lv.dpx;
    w[B2_POL]  = lv.pol;
    return w;
  endfunction

endpackage

// File: rtl/phy_stat_sticky.sv
module phy_stat_sticky #(
  parameter bit LATCH_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic rearm_i,
  output logic q_o
);

  logic q_q;
  logic q_next;

  generate
    if (LATCH_HIGH) begin : g_high
      always_comb q_next = rearm_i ? ev_i : (q_q | ev_i);

      p_capture_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_i |=> q_o);
      p_hold_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_o && !rearm_i) |=> q_o);
    end else begin : g_low
      always_comb q_next = rearm_i ? ev_i : (q_q & ev_i);

      p_capture_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ev_i |=> !q_o);
      p_hold_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!q_o && !rearm_i) |=> !q_o);
    end
  endgenerate

  p_rearm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (q_o == $past(ev_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_next;
  end

  assign q_o = q_q;

endmodule

// File: rtl/phy_stat_decode.sv
module phy_stat_decode #(
  parameter int          ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] ADDR_WORD1 = 5'h01,
  parameter logic [ADDR_W-1:0] ADDR_WORD2 = 5'h11
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit1_o,
  output logic              hit2_o,
  output logic              miss_o
);

  always_comb begin
    hit1_o = rd_i && (addr_i == ADDR_WORD1);
    hit2_o = rd_i && (addr_i == ADDR_WORD2);
    miss_o = rd_i && !hit1_o && !hit2_o;
  end

  always_comb begin
    assert ($onehot0({hit1_o, hit2_o, miss_o}));
  end

endmodule

// File: rtl/phy_stat_regs.sv
module phy_stat_regs
  import phy_stat_pkg::*;
#(
  parameter int                ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] ADDR_WORD1 = 5'h01,
  parameter logic [ADDR_W-1:0] ADDR_WORD2 = 5'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_i,
  input  logic              jabber_i,
  input  logic              tx_act_i,
  input  logic              rx_act_i,
  input  logic              coll_i,
  input  logic              full_dpx_i,
  input  logic              pol_rev_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int NSTICKY = 2;
  localparam bit [NSTICKY-1:0] POLARITY = 2'b10;

  logic rd_word1;
  logic rd_word2;
  logic rd_unmapped;

  logic [NSTICKY-1:0] sticky_ev;
  logic [NSTICKY-1:0] sticky_q;
  logic link_lat;
  logic jab_lat;

  live_t             live;
  logic [WORD_W-1:0] word1;
  logic [WORD_W-1:0] word2;
  logic [WORD_W-1:0] rdata_q;

  phy_stat_decode #(
    .ADDR_W    (ADDR_W),
    .ADDR_WORD1(ADDR_WORD1),
    .ADDR_WORD2(ADDR_WORD2)
  ) u_decode (
    .rd_i  (rd_i),
    .addr_i(addr_i),
    .hit1_o(rd_word1),
    .hit2_o(rd_word2),
    .miss_o(rd_unmapped)
  );

  assign sticky_ev = {jabber_i, link_i};

  generate
    for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
      phy_stat_sticky #(.LATCH_HIGH(POLARITY[i])) u_bit (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ev_i   (sticky_ev[i]),
        .rearm_i(rd_word1),
        .q_o    (sticky_q[i])
      );
    end
  endgenerate

  assign link_lat = sticky_q[0];
  assign jab_lat  = sticky_q[1];

  always_comb begin
    live.tx   = tx_act_i;
    live.rx   = rx_act_i;
    live.col  = coll_i;
    live.link = link_i;
    live.dpx  = full_dpx_i;
    live.pol  = pol_rev_i;
  end

  assign word1 = pack_word1(link_lat, jab_lat);
  assign word2 = pack_word2(live);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      if (rd_word1)      rdata_q <= word1;
      else if (rd_word2) rdata_q <= word2;
      else               rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  p_caps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_word1 |=> (rdata_o[12:11] == 2'b11) && (rdata_o[15:13] == 3'b0)
                 && (rdata_o[10:3] == 8'b0) && !rdata_o[0]);

  p_live_link_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_word2 |=> (rdata_o[10] == $past(link_i)) && (rdata_o[13] == $past(tx_act_i)));

  p_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unmapped |=> (rdata_o == '0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: tb/phy_stat_regs_bench.sv
module phy_stat_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link = 1'b0, jab = 1'b0, tx = 1'b0, rx = 1'b0, col = 1'b0, dpx = 1'b0, pol = 1'b0;
  logic        rd = 1'b0;
  logic [4:0]  addr = 5'h0;
  logic [15:0] rdata;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [4:0] A1 = 5'h01;
  localparam logic [4:0] A2 = 5'h11;
  localparam logic [4:0] AX = 5'h07;

  // {tx, rx, col, link, dpx, pol, jab, expected word 2}
  localparam int NV = 9;
  localparam logic [22:0] VEC [NV] = '{
    {7'b0000000, 16'h0000},
    {7'b1000000, 16'h2000},
    {7'b0100000, 16'h1000},
    {7'b0010000, 16'h0800},
    {7'b0001000, 16'h0400},
    {7'b0000100, 16'h0200},
    {7'b0000010, 16'h0020},
    {7'b1111111, 16'h3E20},
    {7'b1001010, 16'h2420}
  };

  always #4 clk = ~clk;

  phy_stat_regs u_phy_stat_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .link_i(link), .jabber_i(jab), .tx_act_i(tx), .rx_act_i(rx),
    .coll_i(col), .full_dpx_i(dpx), .pol_rev_i(pol),
    .rd_i(rd), .addr_i(addr), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_word(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk("R3 rdata in reset", rdata, 16'h0000);
    link = 1'b1;
    rst_n = 1'b1;
    idle(2);
    chk("R3 rdata after reset", rdata, 16'h0000);
    rd_word(A1, d);
    chk("R3 first word1 read", d, 16'h1800);
    rd_word(A1, d);
    chk("R1 link steady up", d, 16'h1804);

    for (int i = 0; i < NV; i++) begin
      {tx, rx, col, link, dpx, pol, jab} = VEC[i][22:16];
      rd_word(A2, d);
      chk("R5 word2 vector", d, VEC[i][15:0]);
    end

    {tx, rx, col, dpx, pol, jab} = 6'b0;
    link = 1'b1;
    rd_word(A1, d);
    chk("R1 R2 R4 after vectors", d, 16'h1802);
    rd_word(A1, d);
    chk("R6 rearmed", d, 16'h1804);

    @(negedge clk); link = 1'b0;
    @(negedge clk); link = 1'b1;
    idle(2);
    rd_word(A1, d);
    chk("R1 one-cycle drop", d, 16'h1800);
    rd_word(A1, d);
    chk("R1 back up", d, 16'h1804);

    @(negedge clk); jab = 1'b1;
    @(negedge clk); jab = 1'b0;
    idle(3);
    rd_word(A1, d);
    chk("R2 jabber pulse held", d, 16'h1806);
    rd_word(A1, d);
    chk("R2 jabber rearmed", d, 16'h1804);

    @(negedge clk);
    addr = A1; rd = 1'b1; link = 1'b0; jab = 1'b1;
    @(negedge clk);
    rd = 1'b0; link = 1'b1; jab = 1'b0;
    chk("R6 pre-read value", rdata, 16'h1804);
    idle(1);
    chk("R9 rdata holds", rdata, 16'h1804);
    rd_word(A1, d);
    chk("R7 same-cycle events", d, 16'h1802);

    @(negedge clk); link = 1'b0; jab = 1'b1;
    @(negedge clk); link = 1'b1; jab = 1'b0;
    rd_word(A2, d);
    chk("R8 word2 live", d, 16'h0400);
    rd_word(AX, d);
    chk("R8 unmapped zero", d, 16'h0000);
    rd_word(A1, d);
    chk("R8 latches untouched", d, 16'h1802);
    rd_word(A1, d);
    chk("R6 final rearm", d, 16'h1804);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule